// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a 32-lane warp and reduces it to the smallest set of cache-line transactions. Each lane gives an active flag and the byte address of a 4-byte word. Lanes whose addresses fall in the same 128-byte line are merged into one transaction. The block then issues the distinct lines one at a time on a valid/ready request port. Each transaction carries the line address, which is the byte address with its seven offset bits dropped, and a mask of the lanes it serves.

A warp request is accepted only while the block is idle. The block then works through the lanes that still have no transaction. In each cycle it takes the lowest such lane, collects every pending lane that shares its line, and offers the group downstream. When the request port is not ready, the current transaction stays in place unchanged.

When every lane has been served, a one-cycle done pulse marks the end of the warp request. The block is idle again in the next cycle. A fully aligned contiguous access costs one transaction. A contiguous access that starts at a misaligned offset costs exactly two.

Top module: `warp_line_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0 and done is 0.
- R2: in_ready is 1 exactly when the block is idle. A request presented while the block is busy is ignored and does not change the transactions of the request in progress.
- R3: The number of transactions issued for an accepted request equals the number of distinct values of address bits [31:7] among its active lanes.
- R4: Bit i of req_mask is 1 when lane i is active and its bits [31:7] equal req_line. The masks of one request never overlap, and together they cover every active lane.
- R5: Transactions are issued in ascending order of the lowest lane index that maps to each line.
- R6: When lane N reads word N of a 128-byte aligned line, with all lanes active, exactly one transaction is issued and its mask is all ones.
- R7: When 32 contiguous words start at a word offset that is not a multiple of 32, exactly two transactions are issued. When the offset is a multiple of 32, exactly one is issued.
- R8: Address bits [6:0] play no part in grouping. Lanes that share a word, or that sit anywhere within one line, share one transaction.
- R9: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_line and req_mask hold their values.
- R10: A request with no active lanes issues no transaction, and done is 1 in the cycle right after it is accepted.
- R11: done is high for exactly one cycle: the cycle after the last transaction handshake. in_ready is 1 in the following cycle.
- R12: With req_ready held at 1, transactions are issued in consecutive cycles. done therefore arrives N+1 cycles after acceptance, where N is the transaction count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A warp request is presented |
| in_ready | output | 1 | Idle; a warp request is accepted this cycle |
| in_active | input | LANES | Per-lane participation flags |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses; lane i uses bits [i*ADDR_W +: ADDR_W] |
| req_valid | output | 1 | A line transaction is offered |
| req_ready | input | 1 | Downstream takes the offered transaction |
| req_line | output | ADDR_W-7 | Line address (byte address bits [31:7]) |
| req_mask | output | LANES | Lanes served by the offered transaction |
| done | output | 1 | One-cycle pulse ending the warp request |

## Verification
Three kinds of wrong internal state show up quickly at the ports. A corrupted pending mask shows on req_mask within one cycle, as a missing lane, a duplicated lane or an overlap with an earlier mask. It also shows as a wrong transaction count by the time done pulses. A stale or mis-latched line tag shows on req_line at the first transaction that uses it. A busy flag that is wrong shows at once as in_ready high during issue, or as done firing early or twice. Because of this, every error is visible at the latest in the cycle where done is expected.

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFS_W,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [TAG_W-1:0]        req_line,
  output logic [LANES-1:0]        req_mask,
  output logic                    done
);

  logic             busy_q;
  logic [LANES-1:0] pend_q;
  logic [TAG_W-1:0] tag_q [LANES];
  logic [LANES-1:0] match;
  logic [LANE_W-1:0] lead;
  logic [LANES*OFS_W-1:0] unused_offsets;

  wire accept = in_valid && in_ready;

  assign in_ready  = !busy_q;
  assign req_valid = busy_q && (|pend_q);
  assign done      = busy_q && !(|pend_q);
  assign req_line  = tag_q[lead];
  assign req_mask  = match;

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend_q[i]) lead = LANE_W'(i);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign match[g] = pend_q[g] && (tag_q[g] == tag_q[lead]);
    assign unused_offsets[g*OFS_W +: OFS_W] = in_addr[g*ADDR_W +: OFS_W];

    always_ff @(posedge clk)
      if (accept) tag_q[g] <= in_addr[g*ADDR_W + OFS_W +: TAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      pend_q <= in_active;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      pend_q <= pend_q & ~match;
    end
  end

endmodule

// File: rtl/coalescer_checks.sv
module coalescer_checks #(
  parameter int LANES = 32,
  parameter int TAG_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] in_active,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_line,
  input logic [LANES-1:0] req_mask,
  input logic             done
);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_mask));

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);

  p_empty_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_active == '0) |=> done && !req_valid);

  p_first_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_active != '0) |=> req_valid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);

  p_mask_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_mask != '0);

  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || ((req_mask & $past(req_mask)) == '0));

  p_back_to_back_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> req_valid || done);

endmodule

bind warp_line_coalescer coalescer_checks #(.LANES(LANES), .TAG_W(TAG_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_active(in_active), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .req_mask(req_mask), .done(done)
);

// File: tb/tb_warp_line_coalescer.sv
module tb_warp_line_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int L = 32;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, req_ready = 0;
  logic in_ready, req_valid, done;
  logic [L-1:0] in_active = '0;
  logic [L*32-1:0] in_addr = '0;
  logic [24:0] req_line;
  logic [L-1:0] req_mask;

  int checks = 0, fails = 0;
  logic [31:0] lane_addr [L];
  logic [L-1:0] act;
  logic [24:0] exp_line [L];
  logic [L-1:0] exp_mask [L];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_line_coalescer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .req_mask(req_mask), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic compute_expected();
    logic [L-1:0] pend = act;
    exp_n = 0;
    while (pend != '0) begin
      int f = 0;
      logic [L-1:0] m = '0;
      for (int i = L - 1; i >= 0; i--) if (pend[i]) f = i;
      for (int i = 0; i < L; i++)
        if (pend[i] && lane_addr[i][31:7] == lane_addr[f][31:7]) m[i] = 1'b1;
      exp_line[exp_n] = lane_addr[f][31:7];
      exp_mask[exp_n] = m;
      exp_n++;
      pend &= ~m;
    end
  endtask

  task automatic run_case(input bit stall, input bit poke, output int got);
    int cyc = 0;
    bit pv = 0;
    logic [24:0] pl = '0;
    logic [L-1:0] pm = '0;
    compute_expected();
    @(negedge clk);
    check(in_ready == 1'b1, "R2 idle ready", in_ready, 1);
    in_valid = 1; in_active = act;
    for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = lane_addr[i];
    @(posedge clk);
    @(negedge clk);
    in_valid = poke;
    if (poke) begin
      in_active = '1;
      for (int i = 0; i < L; i++) in_addr[i*32 +: 32] = 32'h8000_0000 + i * 256;
    end
    got = 0;
    while (cyc < 400) begin
      bit rdy;
      cyc++;
      if (pv) check(req_valid && req_line == pl && req_mask == pm, "R9 stall hold",
                    {req_line, req_mask}, {pl, pm});
      if (done) break;
      if (req_valid) check(!in_ready, "R2 busy not ready", in_ready, 0);
      rdy = stall ? ($urandom % 3 != 0) : 1'b1;
      req_ready = rdy;
      if (req_valid && rdy) begin
        if (got < exp_n) begin
          check(req_line == exp_line[got], "R5 line order", req_line, exp_line[got]);
          check(req_mask == exp_mask[got], "R4 lane mask", req_mask, exp_mask[got]);
        end
        got++;
      end
      pv = req_valid && !rdy; pl = req_line; pm = req_mask;
      @(negedge clk);
    end
    in_valid = 0; req_ready = 0;
    check(got == exp_n, "R3 transaction count", got, exp_n);
    if (!stall) check(cyc == exp_n + 1, "R12 done timing", cyc, exp_n + 1);
    @(negedge clk);
    check(!done && in_ready, "R11 single done pulse", {done, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1 && req_valid == 0 && done == 0, "R1 reset state",
          {in_ready, req_valid, done}, 3'b100);
    rst_n = 1;

    for (int off = 0; off <= 32; off++) begin
      act = '1;
      for (int i = 0; i < L; i++) lane_addr[i] = 32'h0000_4000 + (off + i) * 4;
      run_case(off[0], off[1], got);
      check(got == ((off % 32 == 0) ? 1 : 2), "R7 contiguous offset", got, (off % 32 == 0) ? 1 : 2);
      if (off == 0) check(exp_mask[0] == '1, "R6 aligned full mask", exp_mask[0], '1);
    end

    act = '1;
    for (int i = 0; i < L; i++) lane_addr[i] = 32'h0001_2344;
    run_case(0, 1, got);
    check(got == 1, "R8 broadcast word", got, 1);

    for (int i = 0; i < L; i++) lane_addr[i] = 32'h0000_0F80 + ((i * 37) & 7'h7F);
    run_case(1, 0, got);
    check(got == 1, "R8 offsets ignored", got, 1);

    act = '0;
    run_case(0, 1, got);
    check(got == 0, "R10 empty request", got, 0);

    act = '1;
    for (int i = 0; i < L; i++) lane_addr[i] = 32'h0000_2000 + ((31 - i) / 8) * 128;
    run_case(0, 0, got);
    check(got == 4, "R5 descending lines", got, 4);

    for (int t = 0; t < 60; t++) begin
      act = $urandom;
      if (t % 7 == 0) act = 32'h8000_0001;
      for (int i = 0; i < L; i++)
        lane_addr[i] = 32'h0010_0000 + ($urandom % 5) * 128 + ($urandom % 2) * 32'h100_0000
                       + ($urandom % 128);
      run_case(t[0], t[1], got);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule